// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block sits between a PWM generator and the gate drivers of a half bridge. Each channel pair takes one reference level. While the reference is high, the first output of the pair (side A) wants to be active. While the reference is low, the second output (side B) wants to be active. On every change of the reference, the output that is leaving its active state drops at once. The output that is entering its active state is held back by a programmable deadtime, so the two switches of a leg are never driven on together.

One setting is shared by all pairs. It has three fields: an enable bit, a two-bit prescaler select that divides the system clock, and a six-bit count of prescaled periods. Insertion happens only when the enable bit is set and the count is nonzero. Otherwise both outputs follow the reference with no added delay. Each output has its own polarity bit, which sets whether its active level is high or low.

All pins are plain level-type control and status signals. No pin carries a stream of data, so the block has no valid/ready handshake and no back-pressure.

Top module: `dt_inserter`

## Requirements
- R1: While reset is asserted, and on the first sample after it, every output pin sits at its inactive level. The inactive level equals the channel's polarity bit.
- R2: When the enable bit is 0 or the count is 0 at a reference change, the entering output becomes active on the first clock edge that samples the new reference level. Side A is active when the reference is 1. Side B is active when the reference is 0.
- R3: When insertion is on, the entering output becomes active exactly count × divide clock edges after the first edge that samples the new reference level. Until then it stays inactive.
- R4: Prescaler select encoding: 00 and 01 divide by 1, 10 divides by 4, and 11 divides by 16.
- R5: The leaving output goes inactive on the first edge that samples the reference change, with or without insertion.
- R6: The two outputs of a pair are never active in the same cycle.
- R7: Each pin equals its channel's active state XOR its polarity bit. A polarity bit of 0 means active high; a polarity bit of 1 means active low.
- R8: Every reference change restarts the deadtime count. A pulse shorter than the deadtime never makes its output active, and the opposite output waits a full deadtime from the pulse's trailing edge.
- R9: The enable bit, the select and the count are sampled only at reference changes. Changing them during a count, or while the reference is steady, leaves the outputs unchanged until the next reference change.
- R10: The first clock edge after reset is treated as a reference change, so outputs come up through the deadtime path.
- R11: Pairs are independent. Activity on one pair's reference leaves the other pairs' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dt_en | input | 1 | Deadtime insertion enable |
| dt_ps | input | 2 | Prescaler select |
| dt_cnt | input | DT_W | Deadtime length in prescaled periods |
| pol | input | 2*NUM_PAIRS | Per-channel polarity; bit 2p is side A of pair p, bit 2p+1 is side B |
| pwm_ref | input | NUM_PAIRS | Complementary reference, one bit per pair |
| ch_out | output | 2*NUM_PAIRS | Gated channel pins, in the same bit order as pol |

## Verification
The hardest situation to reach from the pins is a reference change that lands while a count is still running. The new change must restart both the prescaler phase and the period count, and the pending output must stay inactive. The bench gets there by holding the reference high for fewer cycles than the programmed deadtime. It then checks two things: the swallowed output never comes on, and the opposite side waits a full deadtime from the trailing edge. A second directed case changes every setting field in the middle of a long count, to show that the running count ignores the change and the next reference change uses it.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // width of the prescaler phase counter (largest divide is 16)
  localparam int PRE_W = 4;

  // prescaler select codes
  localparam logic [1:0] PS_ONE_A = 2'b00;
  localparam logic [1:0] PS_ONE_B = 2'b01;
  localparam logic [1:0] PS_FOUR  = 2'b10;
  localparam logic [1:0] PS_SIXT  = 2'b11;

  // reload value of the phase counter: divide ratio minus one
  function automatic logic [PRE_W-1:0] pre_reload(input logic [1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      PS_FOUR: r = PRE_W'(3);
      PS_SIXT: r = PRE_W'(15);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler
  import dt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] reload_q;

  // phase restarts with every reference change; the ratio is latched there
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      reload_q <= '0;
    end else if (restart) begin
      phase_q  <= pre_reload(sel);
      reload_q <= pre_reload(sel);
    end else if (phase_q == '0) begin
      phase_q  <= reload_q;
    end else begin
      phase_q  <= phase_q - 1'b1;
    end
  end

  assign tick = (phase_q == '0);

endmodule

// File: rtl/dt_down_counter.sv
module dt_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] load,
  input  logic         tick,
  output logic         expire
);

  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (restart) begin
      rem_q <= load;
    end else if (tick && (rem_q != '0)) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // the last prescaled period ends on this edge
  assign expire = tick && (rem_q == W'(1));

endmodule

// File: rtl/dt_pair.sv
module dt_pair #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dt_en,
  input  logic [1:0]      dt_ps,
  input  logic [DT_W-1:0] dt_cnt,
  input  logic            ref_in,
  output logic            act_a,
  output logic            act_b
);

  logic            ref_q;
  logic            seen_q;
  logic            ref_chg;
  logic            use_dt;
  logic [DT_W-1:0] cnt_load;
  logic            tick;
  logic            expire;

  // first edge out of reset counts as a reference change
  assign ref_chg  = !seen_q || (ref_in != ref_q);
  assign use_dt   = dt_en && (dt_cnt != '0);
  assign cnt_load = use_dt ? dt_cnt : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
    ref_q <= ref_in;
  end

  dt_prescaler u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (ref_chg),
    .sel     (dt_ps),
    .tick    (tick)
  );

  dt_down_counter #(.W(DT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (ref_chg),
    .load    (cnt_load),
    .tick    (tick),
    .expire  (expire)
  );

  // leaving side drops at once; entering side waits for expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      act_a <= 1'b0;
      act_b <= 1'b0;
    end else if (ref_chg) begin
      if (use_dt) begin
        act_a <= 1'b0;
        act_b <= 1'b0;
      end else begin
        act_a <= ref_in;
        act_b <= !ref_in;
      end
    end else if (expire) begin
      act_a <= ref_q;
      act_b <= !ref_q;
    end
  end

endmodule

// File: rtl/dt_inserter.sv
module dt_inserter #(
  parameter int NUM_PAIRS = 2,
  parameter int DT_W      = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dt_en,
  input  logic [1:0]             dt_ps,
  input  logic [DT_W-1:0]        dt_cnt,
  input  logic [2*NUM_PAIRS-1:0] pol,
  input  logic [NUM_PAIRS-1:0]   pwm_ref,
  output logic [2*NUM_PAIRS-1:0] ch_out
);

  localparam int NUM_CH = 2 * NUM_PAIRS;

  logic [NUM_CH-1:0] act;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dt_pair #(.DT_W(DT_W)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .dt_en  (dt_en),
      .dt_ps  (dt_ps),
      .dt_cnt (dt_cnt),
      .ref_in (pwm_ref[p]),
      .act_a  (act[2*p]),
      .act_b  (act[2*p+1])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pol
    assign ch_out[c] = act[c] ^ pol[c];
  end

endmodule

// File: rtl/dt_inserter_chk.sv
module dt_inserter_chk #(
  parameter int NUM_PAIRS = 2,
  parameter int DT_W      = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   dt_en,
  input logic [1:0]             dt_ps,
  input logic [DT_W-1:0]        dt_cnt,
  input logic [2*NUM_PAIRS-1:0] pol,
  input logic [NUM_PAIRS-1:0]   pwm_ref,
  input logic [2*NUM_PAIRS-1:0] ch_out
);

  logic [2*NUM_PAIRS-1:0] on;
  assign on = ch_out ^ pol;

  // R1: one cycle after a reset edge every pin is at its inactive level
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (on == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    // R6: never both sides of a leg on
    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      !(on[2*p] && on[2*p+1]));

    // R5: the leaving side drops without delay
    p_a_drop_r5: assert property (@(posedge clk) disable iff (rst)
      !pwm_ref[p] |=> !on[2*p]);
    p_b_drop_r5: assert property (@(posedge clk) disable iff (rst)
      pwm_ref[p] |=> !on[2*p+1]);

    // R3: with insertion on, a reference change leaves both sides off
    p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
      (dt_en && (dt_cnt != '0) && (pwm_ref[p] != $past(pwm_ref[p])))
      |=> (!on[2*p] && !on[2*p+1]));

    // R2: with insertion off, the entering side follows at once
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
      (!dt_en && (pwm_ref[p] != $past(pwm_ref[p])))
      |=> (on[2*p] == $past(pwm_ref[p])) && (on[2*p+1] == !$past(pwm_ref[p])));
  end

endmodule

bind dt_inserter dt_inserter_chk #(.NUM_PAIRS(NUM_PAIRS), .DT_W(DT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .dt_en   (dt_en),
  .dt_ps   (dt_ps),
  .dt_cnt  (dt_cnt),
  .pol     (pol),
  .pwm_ref (pwm_ref),
  .ch_out  (ch_out)
);

// File: tb/dt_inserter_test.sv
module dt_inserter_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 9;

  // vector: {en, ps, cnt, expected delay in clock edges}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'd5,  11'd0},
    {1'b1, 2'd0, 6'd0,  11'd0},
    {1'b1, 2'd0, 6'd1,  11'd1},
    {1'b1, 2'd1, 6'd3,  11'd3},
    {1'b1, 2'd2, 6'd2,  11'd8},
    {1'b1, 2'd3, 6'd1,  11'd16},
    {1'b1, 2'd3, 6'd3,  11'd48},
    {1'b1, 2'd0, 6'd63, 11'd63},
    {1'b1, 2'd2, 6'd5,  11'd20}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       dt_en;
  logic [1:0] dt_ps;
  logic [5:0] dt_cnt;
  logic [3:0] pol;
  logic [1:0] pwm_ref;
  logic [3:0] ch_out;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_inserter #(.NUM_PAIRS(2), .DT_W(6)) uut (
    .clk     (clk),
    .rst     (rst),
    .dt_en   (dt_en),
    .dt_ps   (dt_ps),
    .dt_cnt  (dt_cnt),
    .pol     (pol),
    .pwm_ref (pwm_ref),
    .ch_out  (ch_out)
  );

  function automatic bit on(input int i);
    return ch_out[i] ^ pol[i];
  endfunction

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // waits for side 'go' to turn on; the reference was changed at the previous negedge
  task automatic measure(input int go, input int other, input int expd,
                         input string req, input int chg_at);
    int  k = 0;
    int  bad_other = 0;
    int  bad_p1 = 0;
    bit  hit = 0;
    while (!hit && k < 300) begin
      @(negedge clk);
      k++;
      if (on(other)) bad_other++;
      if (ch_out[3:2] != 2'b01) bad_p1++;
      if (on(go)) hit = 1;
      if (k == chg_at) begin
        dt_cnt = 6'd1;
        dt_en  = 1'b0;
        dt_ps  = 2'd3;
      end
    end
    check((k - 1) == expd, req, k - 1, expd);
    check(bad_other == 0, "R5 R6 leaving side off", bad_other, 0);
    check(bad_p1 == 0, "R11 other pair steady", bad_p1, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    finish_run();
  end

  initial begin
    // initial reset, R1
    rst = 1'b1; dt_en = 1'b0; dt_ps = 2'd0; dt_cnt = 6'd0;
    pol = 4'b0000; pwm_ref = 2'b10;
    repeat (3) @(negedge clk);
    check(ch_out == 4'b0000, "R1 reset idle", ch_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ch_out == 4'b0110, "R2 bypass after reset", ch_out, 4'b0110);

    // table walk: both directions for each setting
    for (int i = 0; i < NV; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        string req;
        int    expd;
        expd = int'(VEC[i][10:0]);
        if (expd == 0) req = "R2 delay";
        else if (VEC[i][18:17] >= 2) req = "R4 delay";
        else req = "R3 delay";
        @(negedge clk);
        dt_en  = VEC[i][19];
        dt_ps  = VEC[i][18:17];
        dt_cnt = VEC[i][16:11];
        pwm_ref[0] = (dir == 0);
        if (dir == 0) measure(0, 1, expd, req, 0);
        else          measure(1, 0, expd, req, 0);
      end
    end

    // short pulse swallowed and count restarted, R8
    begin
      int seen_a = 0;
      @(negedge clk);
      dt_en = 1'b1; dt_ps = 2'd0; dt_cnt = 6'd5;
      pwm_ref[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (on(0) || on(1)) seen_a++;
      end
      pwm_ref[0] = 1'b0;
      measure(1, 0, 5, "R8 restart from trailing edge", 0);
      check(seen_a == 0, "R8 pulse swallowed", seen_a, 0);
    end

    // settings changed mid-count and while steady, R9
    @(negedge clk);
    dt_en = 1'b1; dt_ps = 2'd0; dt_cnt = 6'd10;
    pwm_ref[0] = 1'b1;
    measure(0, 1, 10, "R9 running count unaffected", 2);
    repeat (3) @(negedge clk);
    check(on(0) && !on(1), "R9 steady outputs unchanged", {on(1), on(0)}, 1);
    pwm_ref[0] = 1'b0;
    measure(1, 0, 0, "R9 new setting at next change", 0);

    // reset with mixed polarity, first edge through deadtime: R1 R7 R10
    @(negedge clk);
    rst = 1'b1; pol = 4'b0101; pwm_ref = 2'b01;
    dt_en = 1'b1; dt_ps = 2'd0; dt_cnt = 6'd2;
    repeat (2) @(negedge clk);
    check(ch_out == 4'b0101, "R1 idle levels follow polarity", ch_out, 4'b0101);
    rst = 1'b0;
    @(negedge clk);
    check(ch_out == 4'b0101, "R10 first edge held", ch_out, 4'b0101);
    @(negedge clk);
    check(ch_out == 4'b0101, "R10 still held", ch_out, 4'b0101);
    @(negedge clk);
    check(ch_out == 4'b1100, "R7 active levels", ch_out, 4'b1100);

    finish_run();
  end

endmodule